// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Engine

This block is the target side of a two-wire serial bus in front of a byte-wide memory. It handles only the read traffic. It keeps its own address counter. It takes synchronized clock and data lines from the pads, pulls the data line low through an open-drain enable, and presents a read address to a memory whose byte comes back on `mem_rdata`.

A master loads the counter with a write-direction transfer: the device byte, then two address bytes. The high address byte goes first, and every byte is sent most significant bit first.

- If a repeated START follows with the read direction set, the engine returns data from the loaded address.
- If a STOP follows instead, the counter keeps the address and nothing is returned. A later read with no address phase starts from the counter.
- Each acknowledge from the master in the ninth clock asks for the next byte. The counter wraps from the top of the address space to zero.
- A not-acknowledge or a STOP in the ninth clock ends the transfer. Once a transfer ends, the engine ignores the bus until the next START.

Top module: `i2crd_read_engine`

## Requirements
- R1: After reset `sda_oe` is 0, `mem_addr` is 0, and a read without an address phase returns the byte at address 0.
- R2: The first byte after a START is the device byte: a 7-bit identity in bits 7..1 and the direction in bit 0, where 1 means read. The engine acknowledges (drives SDA low in the ninth clock) only when the identity equals `DEV_ID`. On a mismatch it stays silent and acknowledges nothing until the next START.
- R3: After a write-direction device byte, the engine acknowledges two address bytes, high byte first and MSB first. After the low byte, the counter holds the low `AW` bits of the 16-bit value. Bits above `AW` are dropped.
- R4: A repeated START followed by a read-direction device byte returns the byte stored at the loaded address, MSB first, one bit per SCL period.
- R5: A STOP right after the low address byte leaves the loaded address in the counter and returns no data. The next read returns data from that address.
- R6: A STOP after only the high address byte leaves the counter unchanged.
- R7: When the master acknowledges a data byte (SDA low in the ninth clock), the engine sends the byte from the next address.
- R8: The counter steps from 2^AW-1 to 0, both during a sequential read and in the counter value left behind.
- R9: A master not-acknowledge ends the read. The engine then drives nothing on further clocks, and the counter points one past the last byte sent.
- R10: A STOP during the ninth clock of a read ends the read in the same way, leaving the counter one past the last byte sent.
- R11: After a STOP, bytes clocked without a new START are not acknowledged. A START always returns the engine to expecting a device byte, with SDA released.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| mem_addr | output | AW | Read address, equal to the address counter |
| mem_rdata | input | 8 | Byte stored at `mem_addr` |

## Verification
Two actions can fall in the same SCL period: the counter step taken on the ninth-clock rise of a read, and a STOP that ends the read in that same high phase. The bench drives a STOP during the ninth clock. It then expects the bus to be released, the counter to stand one past the byte just sent, and the next read with no address phase to return that following byte. A second overlap is the counter load at the end of the low address byte followed at once by a STOP. The bench judges it by the counter value and by the data returned from the next read.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,   // ignoring the bus until a START
    PH_DEV,    // shifting in the device byte
    PH_WHI,    // shifting in the high address byte
    PH_WLO,    // shifting in the low address byte
    PH_HOLD,   // address loaded, waiting for START or STOP
    PH_TX      // sending data bytes
  } phase_t;

  // Counter step with wrap to zero at 2^aw.
  function automatic int unsigned wrap_inc(int unsigned a, int unsigned aw);
    return (a + 32'd1) & ((32'd1 << aw) - 32'd1);
  endfunction

  function automatic logic id_match(logic [7:0] dev_byte, logic [6:0] id);
    return dev_byte[7:1] == id;
  endfunction

  function automatic logic wants_read(logic [7:0] dev_byte);
    return dev_byte[0];
  endfunction

endpackage

// File: rtl/i2crd_line_sync.sv
module i2crd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_q = scl_sh[STAGES-1];
  assign sda_q = sda_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end

  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2crd_addr_ctr.sv
module i2crd_addr_ctr import i2crd_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= AW'(wrap_inc(32'(cnt), AW));
endmodule

// File: rtl/i2crd_read_engine.sv
module i2crd_read_engine import i2crd_pkg::*; #(
  parameter int         AW          = 16,
  parameter logic [6:0] DEV_ID      = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);
  localparam int         BYTE_W   = 8;
  localparam int         WA_W     = 2 * BYTE_W;
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
  localparam logic [3:0] ACK_DONE = 4'(BYTE_W + 1);

  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  phase_t      phase;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, wa_hi, txbyte;
  logic        mack;
  logic [WA_W-1:0] wa_full;
  logic [AW-1:0]   load_val;

  // Named internal events
  logic bus_rise, bus_fall, ctr_load, ctr_inc, dev_hit, dev_miss, in_idle, in_dev;

  i2crd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign bus_rise = scl_rise & ~start_ev & ~stop_ev;
  assign bus_fall = scl_fall & ~start_ev & ~stop_ev;
  assign wa_full  = {wa_hi, shreg};
  assign load_val = AW'(wa_full);
  assign ctr_load = bus_fall && phase == PH_WLO && bitcnt == ACK_SLOT;
  assign ctr_inc  = bus_rise && phase == PH_TX  && bitcnt == ACK_SLOT;
  assign dev_hit  = bus_fall && phase == PH_DEV && bitcnt == ACK_SLOT &&  id_match(shreg, DEV_ID);
  assign dev_miss = bus_fall && phase == PH_DEV && bitcnt == ACK_SLOT && !id_match(shreg, DEV_ID);
  assign in_idle  = phase == PH_IDLE;
  assign in_dev   = phase == PH_DEV;

  i2crd_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(load_val),
    .inc(ctr_inc), .cnt(mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      wa_hi  <= '0;
      txbyte <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      phase  <= PH_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      unique case (phase)
        PH_DEV, PH_WHI, PH_WLO: begin
          if (bitcnt < ACK_SLOT) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else begin
            bitcnt <= ACK_DONE;
          end
        end
        PH_TX: begin
          if (bitcnt < ACK_SLOT) begin
            bitcnt <= bitcnt + 4'd1;
          end else begin
            mack   <= ~sda_q;
            bitcnt <= ACK_DONE;
          end
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      if (bitcnt == ACK_SLOT) begin
        unique case (phase)
          PH_DEV:         if (id_match(shreg, DEV_ID)) sda_oe <= 1'b1;
                          else phase <= PH_IDLE;
          PH_WHI, PH_WLO: sda_oe <= 1'b1;
          PH_TX:          sda_oe <= 1'b0;
          default: ;
        endcase
      end else if (bitcnt == ACK_DONE) begin
        sda_oe <= 1'b0;
        bitcnt <= '0;
        unique case (phase)
          PH_DEV: begin
            if (wants_read(shreg)) begin
              phase  <= PH_TX;
              txbyte <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
            end else begin
              phase <= PH_WHI;
            end
          end
          PH_WHI: begin
            wa_hi <= shreg;
            phase <= PH_WLO;
          end
          PH_WLO: phase <= PH_HOLD;
          PH_TX: begin
            if (mack) begin
              txbyte <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
            end else begin
              phase <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end else if (phase == PH_TX && bitcnt != 4'd0) begin
        sda_oe <= ~txbyte[3'(4'd7 - bitcnt)];
      end
    end
  end
endmodule

// File: rtl/i2crd_read_engine_chk.sv
module i2crd_read_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_q,
  input logic          sda_oe,
  input logic          in_idle,
  input logic          in_dev,
  input logic          start_ev,
  input logic          dev_miss,
  input logic          ctr_load,
  input logic          ctr_inc,
  input logic [AW-1:0] load_val,
  input logic [AW-1:0] cnt
);
  localparam logic [AW-1:0] TOP_ADDR = '1;

  a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q);

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r11_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (in_dev && !sda_oe));

  a_r2_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dev_miss |=> (in_idle && !sda_oe));

  a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_load |=> cnt == $past(load_val));

  a_r8_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_inc |=> cnt == (($past(cnt) == TOP_ADDR) ? '0 : $past(cnt) + 1'b1));
endmodule

bind i2crd_read_engine i2crd_read_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
  .in_idle(in_idle), .in_dev(in_dev), .start_ev(start_ev), .dev_miss(dev_miss),
  .ctr_load(ctr_load), .ctr_inc(ctr_inc), .load_val(load_val), .cnt(mem_addr)
);

// File: tb/tb_i2crd_read_engine.sv
`timescale 1ns/1ps
module tb_i2crd_read_engine;
  localparam int         AW   = 9;
  localparam logic [6:0] DEV  = 7'h52;
  localparam int         Q    = 6;
  localparam int         SPAN = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata;

  function automatic logic [7:0] pat(int unsigned a);
    return 8'(((a % SPAN) * 37 + 11) ^ ((a % SPAN) >> 3));
  endfunction

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = pat(32'(mem_addr));

  i2crd_read_engine #(.AW(AW), .DEV_ID(DEV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  int nvec = 0, nfail = 0, r12_bad = 0;
  bit done = 0;
  logic prev_oe = 1'b0;

  // R12 monitor: any enable change while the bus clock is high
  always @(posedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) r12_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; step(Q);
    scl_m = 1'b1; step(Q);
    sda_m = 1'b0; step(Q);
    scl_m = 1'b0; step(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; step(Q);
    scl_m = 1'b1; step(Q);
    sda_m = 1'b1; step(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; step(Q);
      scl_m = 1'b1; step(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; step(Q);
    scl_m = 1'b1; step(Q);
    acked = !sda_line;
    scl_m = 1'b0; step(Q);
  endtask

  // mack: master acknowledges; stop9: STOP inside the ninth clock
  task automatic recv_byte(input bit mack, input bit stop9, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      step(Q);
      scl_m = 1'b1; step(Q);
      d[i] = sda_line;
      scl_m = 1'b0;
    end
    sda_m = stop9 ? 1'b0 : !mack; step(Q);
    scl_m = 1'b1; step(Q);
    if (stop9) begin
      sda_m = 1'b1; step(Q);
    end else begin
      scl_m = 1'b0; step(Q);
      sda_m = 1'b1;
    end
  endtask

  task automatic load_addr(input logic [15:0] wa, output bit all_ack);
    bit a0, a1, a2;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte(wa[15:8], a1);
    send_byte(wa[7:0], a2);
    all_ack = a0 & a1 & a2;
  endtask

  // Read n bytes starting at the counter, master NACKs the last one
  task automatic read_run(input int n, input int unsigned first, input string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk(a, "R2", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, 1'b0, d);
      chk(d == pat(first + k), req, d, pat(first + k));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("watchdog expired");
    nfail++;
    finish_run();
  end

  initial begin
    bit ok, a;
    logic [7:0] d;
    int unsigned exp_cnt;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R1: reset state
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    chk(mem_addr == 0, "R1", mem_addr, 0);
    read_run(1, 0, "R1");
    chk(mem_addr == 1, "R9", mem_addr, 1);

    // R3 R4: random read sweep, high address bits beyond AW dropped
    for (int unsigned ad = 0; ad < SPAN + 29; ad += 29) begin
      int unsigned aa = (ad >= SPAN) ? SPAN - 1 : ad;
      logic [15:0] wa = 16'(aa) | 16'((ad % 7) << AW);
      load_addr(wa, ok);
      chk(ok, "R3", ok, 1);
      chk(mem_addr == aa, "R3", mem_addr, aa);
      read_run(1, aa, "R4");
    end

    // R7 R8: sequential read across the top of the address space
    load_addr(16'(SPAN - 3), ok);
    read_run(6, SPAN - 3, "R8");
    chk(mem_addr == 3, "R8", mem_addr, 3);

    // R5: set current address, then a plain read
    load_addr(16'd123, ok);
    bus_stop();
    chk(mem_addr == 123, "R5", mem_addr, 123);
    chk(sda_line == 1'b1, "R5", sda_line, 1);
    read_run(2, 123, "R5");

    // R6: only the high address byte before STOP
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h01, a);
    bus_stop();
    chk(mem_addr == 125, "R6", mem_addr, 125);

    // R2: mismatched identity, then a matching byte with no START
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b1}, a);
    chk(!a, "R2", a, 0);
    send_byte({DEV, 1'b1}, a);
    chk(!a, "R2", a, 0);
    bus_stop();
    chk(mem_addr == 125, "R2", mem_addr, 125);

    // R11: bytes after STOP without START are ignored
    send_byte({DEV, 1'b0}, a);
    chk(!a, "R11", a, 0);
    bus_stop();

    // R9: after NACK the engine drives nothing
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, 1'b0, d);
    chk(d == pat(125), "R9", d, pat(125));
    recv_byte(1'b0, 1'b0, d);
    chk(d == 8'hFF, "R9", d, 8'hFF);
    bus_stop();
    chk(mem_addr == 126, "R9", mem_addr, 126);

    // R10: STOP inside the ninth clock, at the top address
    load_addr(16'(SPAN - 1), ok);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, 1'b1, d);
    chk(d == pat(SPAN - 1), "R10", d, pat(SPAN - 1));
    step(Q);
    exp_cnt = 0;
    chk(mem_addr == exp_cnt, "R10", mem_addr, exp_cnt);
    chk(sda_line == 1'b1, "R10", sda_line, 1);
    read_run(1, 0, "R10");

    // R12: enable only moved with the clock low
    chk(r12_bad == 0, "R12", r12_bad, 0);

    step(Q);
    finish_run();
  end
endmodule